// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Register Processor Core

This block is a compact 16-bit processor core that steps through each instruction over several clock cycles. It reads an instruction word from a single synchronous memory port. When operand B selects an immediate, it reads the word that follows. It then executes the instruction. Loads and stores take one extra memory cycle. The core holds sixteen 16-bit register slots: slot 0 always reads as zero, and slot 15 is a scratch location that is reached only through operand A. It also keeps a zero flag and a greater-than flag.

Instructions cover arithmetic, bitwise logic, shifts, rotates, compare, loads and stores, unconditional and conditional jumps, reading the instruction pointer, a debug output with a one-cycle strobe, and halt. The memory port returns read data one cycle after the address is presented. A write is a single cycle with the write enable high. Software observes progress through the debug port and the halted status.

Top module: `t16_core`

## Requirements
- R1: An instruction word holds the opcode in bits 15:10, the operand A selector in bits 9:6 and the operand B selector in bits 5:2; bits 1:0 are ignored.
- R2: Register 0 always reads as zero; a result aimed at register 0, including a load, is dropped.
- R3: B selector 15 takes the word at IP+1 as operand B, and a non-jump instruction then advances IP by 2. Selectors 0..14 read a register, and IP advances by 1.
- R4: A selector 15 names a scratch slot that can be written, read as operand A, and used as a store address without changing registers 1..14.
- R5: Opcodes 0..6 write A+B, A-B, A&B, A|B, A^B, ~(A|B) and B into A, with 16-bit wraparound.
- R6: Opcodes 9, 10, 11 and 12 shift A by the full 16-bit value of B. Opcode 9 shifts left and opcode 10 shifts right, both filling with zeros. Opcode 11 shifts left and fills each vacated bit with the original bit 0. Opcode 12 shifts right and fills with the sign bit. A count of 16 or more saturates.
- R7: Opcode 13 rotates A left and opcode 14 rotates A right, by B modulo 16.
- R8: Opcode 7 loads A from memory address B. Opcode 8 raises the write enable for exactly one cycle, with address A and data B. Read data arrives one cycle after the address.
- R9: Opcode 15 compares A and B as signed values. It sets z when they are equal and gt when A is greater. It writes no register. Only this opcode changes the flags.
- R10: Opcodes 16..20 load IP with operand B: 16 always, 17 when z is set, 18 when z is clear, 19 when gt is set, 20 when both flags are clear.
- R11: Opcode 21 writes into A the address of that same instruction.
- R12: Opcode 22 places operand B on the debug data output and pulses the debug strobe for exactly one cycle.
- R13: Opcode 23 halts. The halted output stays high, the memory address stays on the halt instruction, and no write or debug strobe follows. Opcodes 24..63 do nothing except advance IP.
- R14: A synchronous active-high reset clears IP, all registers, both flags and the halted state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory word address |
| mem_rdata | input | 16 | Read data for the address presented one cycle earlier |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Store strobe, one cycle per store |
| dbg_data | output | 16 | Value of the last debug instruction |
| dbg_valid | output | 1 | One-cycle strobe per debug instruction |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions assume a memory that answers every address with registered data one cycle later. They also assume that reset is held for at least one clock before any program runs. The bench's memory model reproduces exactly this latency. It rewrites program memory only while reset is asserted, so no fetch ever sees a word change under it. Both programs end in a halt, which keeps the strobe and memory-address properties inside the behaviour the assertions describe.

// File: rtl/t16_pkg.sv
package t16_pkg;
    localparam int DW    = 16;
    localparam int SELW  = 4;
    localparam int OPW   = 6;
    localparam int PADW  = DW - OPW - 2 * SELW;
    localparam int NREG  = 1 << SELW;
    localparam int SHW   = $clog2(DW);

    localparam logic [SELW-1:0] SEL_IMM = '1;

    localparam logic [OPW-1:0] OP_ADD = 6'd0;
    localparam logic [OPW-1:0] OP_SUB = 6'd1;
    localparam logic [OPW-1:0] OP_AND = 6'd2;
    localparam logic [OPW-1:0] OP_OR  = 6'd3;
    localparam logic [OPW-1:0] OP_XOR = 6'd4;
    localparam logic [OPW-1:0] OP_NOR = 6'd5;
    localparam logic [OPW-1:0] OP_MOV = 6'd6;
    localparam logic [OPW-1:0] OP_LOD = 6'd7;
    localparam logic [OPW-1:0] OP_STO = 6'd8;
    localparam logic [OPW-1:0] OP_SLL = 6'd9;
    localparam logic [OPW-1:0] OP_SRL = 6'd10;
    localparam logic [OPW-1:0] OP_SLA = 6'd11;
    localparam logic [OPW-1:0] OP_SRA = 6'd12;
    localparam logic [OPW-1:0] OP_ROL = 6'd13;
    localparam logic [OPW-1:0] OP_ROR = 6'd14;
    localparam logic [OPW-1:0] OP_CMP = 6'd15;
    localparam logic [OPW-1:0] OP_JMP = 6'd16;
    localparam logic [OPW-1:0] OP_JZ  = 6'd17;
    localparam logic [OPW-1:0] OP_JNZ = 6'd18;
    localparam logic [OPW-1:0] OP_JGT = 6'd19;
    localparam logic [OPW-1:0] OP_JLT = 6'd20;
    localparam logic [OPW-1:0] OP_GIP = 6'd21;
    localparam logic [OPW-1:0] OP_DBG = 6'd22;
    localparam logic [OPW-1:0] OP_HLT = 6'd23;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_IMM, ST_EXEC, ST_MEM, ST_HALT
    } state_e;

    // decoded fields kept after the fetch
    typedef struct packed {
        logic [OPW-1:0]  op;
        logic [SELW-1:0] asel;
        logic [SELW-1:0] bsel;
    } fields_t;

    // full instruction word as it arrives from memory
    typedef struct packed {
        fields_t         f;
        logic [PADW-1:0] pad;
    } iword_t;

    // what the execute stage asks the sequencer to do
    typedef struct packed {
        logic [DW-1:0] value;
        logic          wr_a;
        logic          mem_rd;
        logic          mem_wr;
        logic          cmp;
        logic          z;
        logic          gt;
        logic          dbg;
        logic          halt;
    } exec_t;

    function automatic logic [DW-1:0] rot_left(input logic [DW-1:0] v,
                                               input logic [SHW-1:0] n);
        return (v << n) | (v >> (DW - int'(n)));
    endfunction

    function automatic logic [DW-1:0] rot_right(input logic [DW-1:0] v,
                                                input logic [SHW-1:0] n);
        return (v >> n) | (v << (DW - int'(n)));
    endfunction
endpackage

// File: rtl/t16_regfile.sv
module t16_regfile
    import t16_pkg::*;
#(
    parameter int W = DW,
    parameter int N = NREG,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_sel,
    input  logic [AW-1:0] rb_sel,
    output logic [W-1:0]  ra_data,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [AW-1:0] wsel,
    input  logic [W-1:0]  wdata
);
    logic [N-1:0][W-1:0] q;

    for (genvar g = 0; g < N; g++) begin : g_ent
        if (g == 0) begin : g_zero
            // slot 0 has no storage: reads zero, writes vanish
            assign q[g] = '0;
        end else begin : g_reg
            logic [W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)
                    r <= '0;
                else if (we && wsel == AW'(g))
                    r <= wdata;
            end
            assign q[g] = r;
        end
    end

    assign ra_data = q[ra_sel];
    assign rb_data = q[rb_sel];
endmodule

// File: rtl/t16_exec.sv
module t16_exec
    import t16_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [DW-1:0]  ip,
    output exec_t          res
);
    logic [SHW-1:0] rot_n;
    logic [DW-1:0]  low_mask;

    assign rot_n    = b[SHW-1:0];
    // ones in the positions a left shift by b vacates
    assign low_mask = ~({DW{1'b1}} << b);

    always_comb begin
        res       = '0;
        res.value = a;
        case (op)
            OP_ADD: begin res.value = a + b;     res.wr_a = 1'b1; end
            OP_SUB: begin res.value = a - b;     res.wr_a = 1'b1; end
            OP_AND: begin res.value = a & b;     res.wr_a = 1'b1; end
            OP_OR:  begin res.value = a | b;     res.wr_a = 1'b1; end
            OP_XOR: begin res.value = a ^ b;     res.wr_a = 1'b1; end
            OP_NOR: begin res.value = ~(a | b);  res.wr_a = 1'b1; end
            OP_MOV: begin res.value = b;         res.wr_a = 1'b1; end
            OP_SLL: begin res.value = a << b;    res.wr_a = 1'b1; end
            OP_SRL: begin res.value = a >> b;    res.wr_a = 1'b1; end
            OP_SLA: begin
                res.value = (a << b) | ({DW{a[0]}} & low_mask);
                res.wr_a  = 1'b1;
            end
            OP_SRA: begin
                res.value = $signed(a) >>> b;
                res.wr_a  = 1'b1;
            end
            OP_ROL: begin res.value = rot_left(a, rot_n);  res.wr_a = 1'b1; end
            OP_ROR: begin res.value = rot_right(a, rot_n); res.wr_a = 1'b1; end
            OP_GIP: begin res.value = ip;        res.wr_a = 1'b1; end
            OP_LOD: res.mem_rd = 1'b1;
            OP_STO: res.mem_wr = 1'b1;
            OP_CMP: begin
                res.cmp = 1'b1;
                res.z   = (a == b);
                res.gt  = ($signed(a) > $signed(b));
            end
            OP_DBG: res.dbg  = 1'b1;
            OP_HLT: res.halt = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/t16_nextip.sv
module t16_nextip
    import t16_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic           has_imm,
    input  logic [DW-1:0]  ip,
    input  logic [DW-1:0]  target,
    input  logic           z,
    input  logic           gt,
    output logic [DW-1:0]  nip
);
    logic take;

    always_comb begin
        case (op)
            OP_JMP:  take = 1'b1;
            OP_JZ:   take = z;
            OP_JNZ:  take = !z;
            OP_JGT:  take = gt;
            OP_JLT:  take = !z && !gt;
            default: take = 1'b0;
        endcase
    end

    always_comb begin
        if (op == OP_HLT)
            nip = ip;
        else if (take)
            nip = target;
        else
            nip = ip + (has_imm ? DW'(2) : DW'(1));
    end
endmodule

// File: rtl/t16_core.sv
module t16_core
    import t16_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [15:0]   mem_addr,
    input  logic [15:0]   mem_rdata,
    output logic [15:0]   mem_wdata,
    output logic          mem_we,
    output logic [15:0]   dbg_data,
    output logic          dbg_valid,
    output logic          halted
);
    state_e        st;
    logic [DW-1:0] ip;
    logic [DW-1:0] imm;
    fields_t       ir;
    logic          z_f;
    logic          gt_f;

    logic [DW-1:0] ra_data;
    logic [DW-1:0] rb_data;
    logic [DW-1:0] b_val;
    logic [DW-1:0] nip;
    logic          b_is_imm;
    logic          rf_we;
    logic [DW-1:0] rf_wdata;
    exec_t         res;
    iword_t        fetched;
    logic          unused_pad;

    assign fetched    = iword_t'(mem_rdata);
    assign unused_pad = ^fetched.pad;

    assign b_is_imm = (ir.bsel == SEL_IMM);
    assign b_val    = b_is_imm ? imm : rb_data;

    t16_regfile #(.W(DW), .N(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_sel  (ir.asel),
        .rb_sel  (ir.bsel),
        .ra_data (ra_data),
        .rb_data (rb_data),
        .we      (rf_we),
        .wsel    (ir.asel),
        .wdata   (rf_wdata)
    );

    t16_exec u_exec (
        .op  (ir.op),
        .a   (ra_data),
        .b   (b_val),
        .ip  (ip),
        .res (res)
    );

    t16_nextip u_nip (
        .op      (ir.op),
        .has_imm (b_is_imm),
        .ip      (ip),
        .target  (b_val),
        .z       (z_f),
        .gt      (gt_f),
        .nip     (nip)
    );

    // register write: ALU results in execute, load data in the wait state
    assign rf_we    = (st == ST_EXEC && res.wr_a) || (st == ST_MEM && res.mem_rd);
    assign rf_wdata = (st == ST_MEM) ? mem_rdata : res.value;

    always_comb begin
        case (st)
            ST_DECODE: mem_addr = ip + DW'(1);   // speculative immediate read
            ST_EXEC, ST_MEM: begin
                if (res.mem_rd)      mem_addr = b_val;
                else if (res.mem_wr) mem_addr = ra_data;
                else                 mem_addr = ip;
            end
            default:   mem_addr = ip;
        endcase
    end

    assign mem_we    = (st == ST_EXEC) && res.mem_wr;
    assign mem_wdata = b_val;
    assign halted    = (st == ST_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_FETCH;
            ip        <= '0;
            imm       <= '0;
            ir        <= '0;
            z_f       <= 1'b0;
            gt_f      <= 1'b0;
            dbg_data  <= '0;
            dbg_valid <= 1'b0;
        end else begin
            dbg_valid <= 1'b0;
            case (st)
                ST_FETCH: st <= ST_DECODE;
                ST_DECODE: begin
                    ir <= fetched.f;
                    st <= (fetched.f.bsel == SEL_IMM) ? ST_IMM : ST_EXEC;
                end
                ST_IMM: begin
                    imm <= mem_rdata;
                    st  <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (res.cmp) begin
                        z_f  <= res.z;
                        gt_f <= res.gt;
                    end
                    if (res.dbg) begin
                        dbg_data  <= b_val;
                        dbg_valid <= 1'b1;
                    end
                    if (res.halt) begin
                        st <= ST_HALT;
                    end else if (res.mem_rd || res.mem_wr) begin
                        st <= ST_MEM;
                    end else begin
                        ip <= nip;
                        st <= ST_FETCH;
                    end
                end
                ST_MEM: begin
                    ip <= nip;
                    st <= ST_FETCH;
                end
                ST_HALT: st <= ST_HALT;
                default: st <= ST_FETCH;
            endcase
        end
    end
endmodule

// File: rtl/t16_core_chk.sv
module t16_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        dbg_valid,
    input logic        halted
);
    // R13: once halted, stay halted
    a_r13_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R13: no store or debug strobe while halted
    a_r13_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_we && !dbg_valid));

    // R13: IP frozen while halted
    a_r13_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(mem_addr));

    // R12: debug strobe lasts one cycle
    a_r12_dbg_pulse: assert property (@(posedge clk) disable iff (rst)
        dbg_valid |=> !dbg_valid);

    // R8: a store writes for a single cycle
    a_r8_store_single: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R14: reset leaves the core idle at address zero
    a_r14_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!halted && !mem_we && !dbg_valid && mem_addr == 16'h0000));
endmodule

bind t16_core t16_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .dbg_valid (dbg_valid),
    .halted    (halted)
);

// File: tb/tb_t16_core.sv
module tb_t16_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_rdata, mem_wdata, dbg_data;
    logic        mem_we, dbg_valid, halted;

    always #10 clk = ~clk;   // 50 MHz

    t16_core dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .dbg_data(dbg_data),
        .dbg_valid(dbg_valid), .halted(halted)
    );

    // memory model: one-cycle registered read
    logic [15:0] mem [1024];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    int checks = 0;
    int fails  = 0;

    // scoreboard queues
    logic [15:0] dq[$];
    string       dreq[$];
    logic [31:0] sq[$];
    string       sreq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && dbg_valid) begin
            if (dq.size() == 0)
                check(1'b0, "R12", "unexpected debug strobe", {16'h0, dbg_data}, 32'h0);
            else begin
                logic [15:0] e;
                string       r;
                e = dq.pop_front();
                r = dreq.pop_front();
                check(dbg_data == e, r, "debug value", {16'h0, dbg_data}, {16'h0, e});
            end
        end
        if (!rst && mem_we) begin
            if (sq.size() == 0)
                check(1'b0, "R8", "unexpected store", {mem_addr, mem_wdata}, 32'h0);
            else begin
                logic [31:0] e;
                string       r;
                e = sq.pop_front();
                r = sreq.pop_front();
                check({mem_addr, mem_wdata} == e, r, "store addr/data",
                      {mem_addr, mem_wdata}, e);
            end
        end
    end

    // program builder
    int pc;

    function automatic logic [15:0] enc(input int op, input int a, input int b);
        return {op[5:0], a[3:0], b[3:0], 2'b00};
    endfunction

    task automatic put(input logic [15:0] w);
        mem[pc[9:0]] = w;
        pc++;
    endtask

    task automatic ins(input int op, input int a, input int b);
        put(enc(op, a, b));
    endtask

    task automatic insi(input int op, input int a, input logic [15:0] v);
        put(enc(op, a, 15));
        put(v);
    endtask

    task automatic exp_dbg(input logic [15:0] v, input string req);
        dq.push_back(v);
        dreq.push_back(req);
    endtask

    task automatic dbgr(input int r, input logic [15:0] v, input string req);
        ins(22, 0, r);
        exp_dbg(v, req);
    endtask

    task automatic dbgi(input logic [15:0] v, input bit expect_it, input string req);
        insi(22, 0, v);
        if (expect_it) exp_dbg(v, req);
    endtask

    task automatic shtest(input int op, input logic [15:0] amt,
                          input logic [15:0] e, input string req);
        insi(6, 7, 16'h8421);
        insi(op, 7, amt);
        dbgr(7, e, req);
    endtask

    // jump to pc+4 skips the 2-word debug marker; landing marker always runs
    task automatic jtest(input int op, input bit taken, input logic [15:0] mk,
                         input string req);
        logic [15:0] t;
        t = 16'(pc + 4);
        insi(op, 0, t);
        dbgi(mk, !taken, req);
        dbgi(mk | 16'h8000, 1'b1, req);
    endtask

    task automatic clear_mem;
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        pc = 0;
    endtask

    int hlt_pc;

    task automatic run_until_halt(input string req);
        int n;
        n = 0;
        while (!halted && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(halted == 1'b1, req, "halt reached before watchdog", {31'h0, halted}, 32'h1);
        repeat (12) @(negedge clk);
        check(halted == 1'b1, "R13", "halted stays high", {31'h0, halted}, 32'h1);
        check(mem_addr == 16'(hlt_pc), "R13", "IP frozen on halt",
              {16'h0, mem_addr}, hlt_pc);
        check(dq.size() == 0, "R12", "all debug values seen", dq.size(), 0);
        check(sq.size() == 0, "R8", "all stores seen", sq.size(), 0);
    endtask

    task automatic build_prog1;
        clear_mem();
        // R5 arithmetic and logic, R3 immediate, R1 padding bits ignored
        insi(6, 1, 16'h1234);
        put(enc(6, 2, 15) | 16'h0003);          // R1: nonzero pad bits ignored
        put(16'h00F0);
        dbgr(1, 16'h1234, "R3");
        dbgr(2, 16'h00F0, "R1");
        ins(0, 1, 2);            dbgr(1, 16'h1324, "R5");
        insi(6, 3, 16'h0005); insi(1, 3, 16'h0007); dbgr(3, 16'hFFFE, "R5");
        insi(6, 4, 16'hF0F0); insi(2, 4, 16'h3C3C); dbgr(4, 16'h3030, "R5");
        insi(3, 4, 16'h0101);   dbgr(4, 16'h3131, "R5");
        insi(4, 4, 16'hFFFF);   dbgr(4, 16'hCECE, "R5");
        insi(6, 5, 16'h1200); insi(5, 5, 16'h0034); dbgr(5, 16'hEDCB, "R5");
        insi(6, 0, 16'h0055);   dbgr(0, 16'h0000, "R2");
        ins(6, 6, 1);           dbgr(6, 16'h1324, "R3");
        // R6 shifts, R7 rotates
        shtest(9,  16'd4,  16'h4210, "R6");
        shtest(10, 16'd4,  16'h0842, "R6");
        shtest(12, 16'd4,  16'hF842, "R6");
        shtest(11, 16'd4,  16'h421F, "R6");
        shtest(9,  16'd16, 16'h0000, "R6");
        shtest(10, 16'd17, 16'h0000, "R6");
        shtest(12, 16'd20, 16'hFFFF, "R6");
        shtest(11, 16'd16, 16'hFFFF, "R6");
        shtest(13, 16'd20, 16'h4218, "R7");
        shtest(14, 16'd4,  16'h1842, "R7");
        shtest(14, 16'd16, 16'h8421, "R7");
        insi(6, 8, 16'd3); insi(6, 7, 16'h8421); ins(9, 7, 8); dbgr(7, 16'h2108, "R6");
        // R8 load/store
        insi(6, 9, 16'h0300);
        insi(8, 9, 16'hBEEF);   sq.push_back({16'h0300, 16'hBEEF}); sreq.push_back("R8");
        ins(7, 10, 9);          dbgr(10, 16'hBEEF, "R8");
        insi(7, 11, 16'h0300);  dbgr(11, 16'hBEEF, "R8");
        insi(7, 0, 16'h0300);   dbgr(0, 16'h0000, "R2");
        // R4 scratch slot
        insi(6, 15, 16'h7777);
        insi(15, 15, 16'h7777);
        jtest(17, 1'b1, 16'h0071, "R4");
        insi(8, 15, 16'hABCD);  sq.push_back({16'h7777, 16'hABCD}); sreq.push_back("R4");
        dbgr(1, 16'h1324, "R4");
        dbgr(14, 16'h0000, "R4");
        // R9 compare, R10 jumps
        insi(6, 1, 16'h0005);
        insi(15, 1, 16'h0005);              // z=1 gt=0
        jtest(17, 1'b1, 16'h0011, "R10");
        jtest(18, 1'b0, 16'h0012, "R10");
        jtest(19, 1'b0, 16'h0013, "R10");
        jtest(20, 1'b0, 16'h0014, "R10");
        insi(0, 2, 16'h0001);               // non-compare leaves flags
        jtest(17, 1'b1, 16'h0015, "R9");
        insi(15, 1, 16'h0003);              // gt
        jtest(19, 1'b1, 16'h0021, "R10");
        jtest(20, 1'b0, 16'h0022, "R10");
        jtest(17, 1'b0, 16'h0023, "R10");
        jtest(18, 1'b1, 16'h0024, "R10");
        insi(15, 1, 16'hFFFF);              // 5 > -1 signed
        jtest(19, 1'b1, 16'h0031, "R9");
        insi(15, 1, 16'h0007);              // less
        jtest(20, 1'b1, 16'h0041, "R10");
        jtest(19, 1'b0, 16'h0042, "R10");
        insi(6, 3, 16'h8000);
        insi(15, 3, 16'h0001);              // -32768 < 1 signed
        jtest(20, 1'b1, 16'h0051, "R9");
        jtest(16, 1'b1, 16'h0061, "R10");
        dbgr(1, 16'h0005, "R9");
        // R11 gip
        begin
            int p;
            p = pc;
            ins(21, 13, 0);
            dbgr(13, 16'(p), "R11");
        end
        // R13 no-op opcodes, with and without immediate
        ins(30, 1, 2);             dbgr(1, 16'h0005, "R13");
        insi(40, 1, 16'h1111);     dbgr(1, 16'h0005, "R13");
        ins(63, 1, 0);             dbgr(1, 16'h0005, "R13");
        hlt_pc = pc;
        ins(23, 0, 0);
        dbgi(16'hDEAD, 1'b0, "R13");
    endtask

    task automatic build_prog2;
        clear_mem();
        dbgr(1, 16'h0000, "R14");
        jtest(17, 1'b0, 16'h00A1, "R14");   // z cleared by reset
        jtest(19, 1'b0, 16'h00A2, "R14");   // gt cleared by reset
        jtest(20, 1'b1, 16'h00A3, "R14");
        hlt_pc = pc;
        ins(23, 0, 0);
    endtask

    initial begin
        rst = 1'b1;
        build_prog1();
        repeat (3) @(negedge clk);
        check(halted == 1'b0,      "R14", "halted in reset",  {31'h0, halted}, 0);
        check(mem_we == 1'b0,      "R14", "we in reset",      {31'h0, mem_we}, 0);
        check(dbg_valid == 1'b0,   "R14", "dbg in reset",     {31'h0, dbg_valid}, 0);
        check(mem_addr == 16'h0,   "R14", "addr in reset",    {16'h0, mem_addr}, 0);
        rst = 1'b0;
        run_until_halt("R13");

        rst = 1'b1;
        @(negedge clk);
        check(halted == 1'b0, "R14", "reset clears halt", {31'h0, halted}, 0);
        build_prog2();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run_until_halt("R14");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule